// File: doc/BRIEF.md
# Return Address Stack with Program Counter Interface

This block holds the return addresses of a small sequencer. It keeps a program counter and an eight-slot last-in, first-out store built as a shift register. A subroutine call saves the address after the call instruction and jumps to a target. An accepted interrupt saves the current program counter, jumps to an externally supplied vector, and masks further interrupts. A return loads the program counter from the newest slot. Software can also push and pop a plain 16-bit word through the same store. Only the newest slot is visible at the ports.

The store has no pointer and does not detect overflow. Every push moves all slots one place deeper, and whatever sat in the deepest slot is lost. Every pop moves all slots one place toward the top, and the deepest slot keeps its value. Popping past the last saved word therefore keeps returning copies of the deepest value.

Interrupt masking is a two-state machine. In state `ST_OPEN`, interrupts are accepted. In state `ST_MASKED`, they are ignored. Transition `T_TAKE` goes from `ST_OPEN` to `ST_MASKED` when an interrupt is accepted. Transition `T_UNMASK` goes from `ST_MASKED` to `ST_OPEN` when the enable strobe is high. In every other case the machine stays in its state (`T_STAY`).

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the program counter is 0, every slot holds 0, the visible top word is 0, the popped-word register is 0 and the interrupt enable output is 1.
- R2: An explicit push places `push_data` in the top slot, and the previous top becomes the second slot.
- R3: A push moves every slot one place deeper. After nine pushes with no pop, the first word pushed is lost, and eight pops return the other eight words, newest first.
- R4: Any pop (explicit or return) copies the old top word into `pop_word` and moves every slot one place up. The deepest slot keeps its value, so further pops keep returning it.
- R5: A call pushes the program counter plus one and loads the program counter with `target`.
- R6: A return loads the program counter with the top word and pops it.
- R7: An interrupt request while enabled pushes the current program counter, loads `target`, and drops the interrupt enable to 0.
- R8: An interrupt request while masked changes neither the program counter nor the stack nor the enable.
- R9: An enable strobe while masked sets the interrupt enable back to 1 in the next cycle.
- R10: When a pop-class request (return or pop) and a push-class request arrive in the same cycle, only the pop is performed. The push is dropped. If both a return and a pop are requested, the return wins and there is a single pop.
- R11: With no call, return, accepted interrupt or pop, `advance` increments the program counter by one. Without `advance`, the program counter holds.
- R12: Among push-class requests, an accepted interrupt beats a call, and a call beats an explicit push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Subroutine call strobe |
| ret_req | input | 1 | Subroutine return strobe |
| push_req | input | 1 | Explicit data push strobe |
| pop_req | input | 1 | Explicit data pop strobe |
| irq_req | input | 1 | Interrupt request |
| irq_unmask | input | 1 | Interrupt enable strobe |
| advance | input | 1 | Step the program counter by one |
| target | input | 16 | Call target or interrupt vector |
| push_data | input | 16 | Word for an explicit push |
| pc | output | 16 | Program counter |
| top_word | output | 16 | Newest stack slot |
| pop_word | output | 16 | Word removed by the latest pop |
| irq_enabled | output | 1 | 1 while in ST_OPEN |

## Verification
The table-driven run mixes the following patterns and checks the program counter, the top word, the popped word and the enable after each cycle:
- single strobes;
- call followed by return;
- interrupt while enabled against interrupt while masked;
- push and pop together;
- a three-way call, push and interrupt collision;
- return and pop together.

Each pattern separates one priority or one masking rule from its neighbours. A directed fill with nine distinct words, followed by nine pops, tells the drop of the deepest slot on overflow apart from the duplication of the deepest slot on underflow.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic {ST_OPEN, ST_MASKED} ien_state_e;
    typedef enum logic [1:0] {SO_NONE, SO_PUSH, SO_POP} stk_op_e;
    typedef enum logic [1:0] {PW_PC, PW_PC_INC, PW_DATA} push_src_e;
    typedef enum logic [1:0] {PC_HOLD, PC_STEP, PC_TARGET, PC_TOP} pc_sel_e;
endpackage

// File: rtl/rs_arbiter.sv
module rs_arbiter
    import rs_pkg::*;
(
    input  logic      call_req,
    input  logic      ret_req,
    input  logic      push_req,
    input  logic      pop_req,
    input  logic      irq_req,
    input  logic      advance,
    input  logic      irq_open,
    output stk_op_e   stk_op,
    output push_src_e push_src,
    output pc_sel_e   pc_sel,
    output logic      irq_take
);
    logic any_pop;

    always_comb begin
        any_pop  = ret_req | pop_req;
        irq_take = irq_req & irq_open & ~any_pop;
        stk_op   = SO_NONE;
        push_src = PW_DATA;
        pc_sel   = advance ? PC_STEP : PC_HOLD;
        if (any_pop) begin
            stk_op = SO_POP;
            if (ret_req) pc_sel = PC_TOP;
        end else if (irq_take) begin
            stk_op   = SO_PUSH;
            push_src = PW_PC;
            pc_sel   = PC_TARGET;
        end else if (call_req) begin
            stk_op   = SO_PUSH;
            push_src = PW_PC_INC;
            pc_sel   = PC_TARGET;
        end else if (push_req) begin
            stk_op   = SO_PUSH;
            push_src = PW_DATA;
        end
    end
endmodule

// File: rtl/rs_shift_stack.sv
module rs_shift_stack
    import rs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  stk_op_e      stk_op,
    input  logic [W-1:0] wr_word,
    output logic [W-1:0] top
);
    localparam int LAST = DEPTH - 1;

    logic [W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] from_above;
        logic [W-1:0] from_below;
        if (i == 0) begin : g_first
            assign from_above = wr_word;
        end else begin : g_inner_a
            assign from_above = slot[i-1];
        end
        if (i == LAST) begin : g_last
            assign from_below = slot[i];
        end else begin : g_inner_b
            assign from_below = slot[i+1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else begin
                unique case (stk_op)
                    SO_PUSH: slot[i] <= from_above;
                    SO_POP:  slot[i] <= from_below;
                    default: slot[i] <= slot[i];
                endcase
            end
        end
    end

    assign top = slot[0];
endmodule

// File: rtl/rs_pc_unit.sv
module rs_pc_unit
    import rs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pc_sel_e      pc_sel,
    input  logic [W-1:0] target,
    input  logic [W-1:0] top,
    output logic [W-1:0] pc,
    output logic [W-1:0] pc_inc
);
    assign pc_inc = pc + W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            unique case (pc_sel)
                PC_STEP:   pc <= pc_inc;
                PC_TARGET: pc <= target;
                PC_TOP:    pc <= top;
                default:   pc <= pc;
            endcase
        end
    end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import rs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          irq_req,
    input  logic          irq_unmask,
    input  logic          advance,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] top_word,
    output logic [AW-1:0] pop_word,
    output logic          irq_enabled
);
    ien_state_e    state_q, state_d;
    stk_op_e       stk_op;
    push_src_e     push_src;
    pc_sel_e       pc_sel;
    logic          irq_take;
    logic [AW-1:0] pc_inc;
    logic [AW-1:0] wr_word;

    rs_arbiter i_arb (
        .call_req (call_req),
        .ret_req  (ret_req),
        .push_req (push_req),
        .pop_req  (pop_req),
        .irq_req  (irq_req),
        .advance  (advance),
        .irq_open (state_q == ST_OPEN),
        .stk_op   (stk_op),
        .push_src (push_src),
        .pc_sel   (pc_sel),
        .irq_take (irq_take)
    );

    always_comb begin
        unique case (push_src)
            PW_PC:     wr_word = pc;
            PW_PC_INC: wr_word = pc_inc;
            default:   wr_word = push_data;
        endcase
    end

    rs_shift_stack #(.DEPTH(DEPTH), .W(AW)) i_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .stk_op  (stk_op),
        .wr_word (wr_word),
        .top     (top_word)
    );

    rs_pc_unit #(.W(AW)) i_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .pc_sel (pc_sel),
        .target (target),
        .top    (top_word),
        .pc     (pc),
        .pc_inc (pc_inc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // transitions: T_TAKE, T_UNMASK, T_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (irq_take)   state_d = ST_MASKED;
            ST_MASKED: if (irq_unmask) state_d = ST_OPEN;
            default:   state_d = ST_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_OPEN: irq_enabled = 1'b1;
            default: irq_enabled = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 pop_word <= '0;
        else if (stk_op == SO_POP)  pop_word <= top_word;
    end
endmodule

// File: rtl/rs_stack_chk.sv
module rs_stack_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          call_req,
    input logic          ret_req,
    input logic          pop_req,
    input logic          irq_req,
    input logic          irq_unmask,
    input logic          advance,
    input logic [AW-1:0] target,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] top_word,
    input logic [AW-1:0] pop_word,
    input logic          irq_enabled
);
    // R5
    call_saves_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !ret_req && !pop_req && !(irq_req && irq_enabled))
        |=> (top_word == AW'($past(pc) + 1'b1)) && (pc == $past(target)));

    // R6
    ret_loads_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req |=> pc == $past(top_word));

    // R4
    pop_captures_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req || pop_req) |=> pop_word == $past(top_word));

    // R7
    irq_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_enabled && !ret_req && !pop_req) |=> !irq_enabled);

    // R8
    masked_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_enabled && !irq_unmask) |=> !irq_enabled);

    // R9
    unmask_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_enabled && irq_unmask) |=> irq_enabled);

    // R11
    step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !call_req && !ret_req && !pop_req && !(irq_req && irq_enabled))
        |=> pc == AW'($past(pc) + 1'b1));
endmodule

bind ret_addr_stack rs_stack_chk #(.AW(AW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_req    (call_req),
    .ret_req     (ret_req),
    .pop_req     (pop_req),
    .irq_req     (irq_req),
    .irq_unmask  (irq_unmask),
    .advance     (advance),
    .target      (target),
    .pc          (pc),
    .top_word    (top_word),
    .pop_word    (pop_word),
    .irq_enabled (irq_enabled)
);

// File: tb/test_ret_addr_stack.sv
`timescale 1ns/1ps
module test_ret_addr_stack;
    localparam int AW = 16;
    localparam int NV = 14;
    localparam int VW = 88;
    localparam logic [6:0] C_ADV  = 7'b0000001;
    localparam logic [6:0] C_IEN  = 7'b0000010;
    localparam logic [6:0] C_IRQ  = 7'b0000100;
    localparam logic [6:0] C_POP  = 7'b0001000;
    localparam logic [6:0] C_PUSH = 7'b0010000;
    localparam logic [6:0] C_RET  = 7'b0100000;
    localparam logic [6:0] C_CALL = 7'b1000000;

    // {ctrl, target, data, exp_pc, exp_top, exp_ien, exp_pop}
    localparam logic [VW-1:0] VEC [NV] = '{
        {C_ADV,  16'h0000, 16'h0000, 16'h0001, 16'h0000, 1'b1, 16'h0000},
        {C_ADV,  16'h0000, 16'h0000, 16'h0002, 16'h0000, 1'b1, 16'h0000},
        {C_CALL, 16'h0100, 16'h0000, 16'h0100, 16'h0003, 1'b1, 16'h0000},
        {C_PUSH, 16'h0000, 16'hAAAA, 16'h0100, 16'hAAAA, 1'b1, 16'h0000},
        {C_POP,  16'h0000, 16'h0000, 16'h0100, 16'h0003, 1'b1, 16'hAAAA},
        {C_IRQ,  16'h0200, 16'h0000, 16'h0200, 16'h0100, 1'b0, 16'hAAAA},
        {C_IRQ,  16'h0300, 16'h0000, 16'h0200, 16'h0100, 1'b0, 16'hAAAA},
        {C_IEN,  16'h0000, 16'h0000, 16'h0200, 16'h0100, 1'b1, 16'hAAAA},
        {C_RET,  16'h0000, 16'h0000, 16'h0100, 16'h0003, 1'b1, 16'h0100},
        {C_PUSH | C_POP, 16'h0000, 16'h5555, 16'h0100, 16'h0000, 1'b1, 16'h0003},
        {C_CALL | C_PUSH | C_IRQ, 16'h0400, 16'h1234, 16'h0400, 16'h0100, 1'b0, 16'h0003},
        {C_RET,  16'h0000, 16'h0000, 16'h0100, 16'h0000, 1'b0, 16'h0100},
        {C_CALL | C_PUSH, 16'h0500, 16'h7777, 16'h0500, 16'h0101, 1'b0, 16'h0100},
        {C_RET | C_POP, 16'h0000, 16'h0000, 16'h0101, 16'h0000, 1'b0, 16'h0101}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_req = 1'b0, ret_req = 1'b0, push_req = 1'b0, pop_req = 1'b0;
    logic          irq_req = 1'b0, irq_unmask = 1'b0, advance = 1'b0;
    logic [AW-1:0] target = '0, push_data = '0;
    logic [AW-1:0] pc, top_word, pop_word;
    logic          irq_enabled;
    int            checks = 0;
    int            fails = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    ret_addr_stack i_ret_addr_stack (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
        .push_req(push_req), .pop_req(pop_req), .irq_req(irq_req),
        .irq_unmask(irq_unmask), .advance(advance), .target(target),
        .push_data(push_data), .pc(pc), .top_word(top_word),
        .pop_word(pop_word), .irq_enabled(irq_enabled)
    );

    function automatic string vec_req(int k);
        case (k)
            0, 1:   return "R11";
            2:      return "R5";
            3:      return "R2";
            4:      return "R4";
            5:      return "R7";
            6:      return "R8";
            7:      return "R9";
            8:      return "R6";
            9:      return "R10";
            10, 12: return "R12";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [6:0] c, logic [AW-1:0] t, logic [AW-1:0] d);
        @(negedge clk);
        {call_req, ret_req, push_req, pop_req, irq_req, irq_unmask, advance} = c;
        target    = t;
        push_data = d;
        @(posedge clk);
        #1;
        {call_req, ret_req, push_req, pop_req, irq_req, irq_unmask, advance} = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "pc", pc, 16'h0000);
        chk("R1", "top", top_word, 16'h0000);
        chk("R1", "pop", pop_word, 16'h0000);
        chk("R1", "ien", {15'd0, irq_enabled}, 16'h0001);

        for (int k = 0; k < NV; k++) begin
            logic [VW-1:0] v;
            v = VEC[k];
            drive(v[87:81], v[80:65], v[64:49]);
            chk(vec_req(k), "pc", pc, v[48:33]);
            chk(vec_req(k), "top", top_word, v[32:17]);
            chk(vec_req(k), "ien", {15'd0, irq_enabled}, {15'd0, v[16]});
            chk(vec_req(k), "pop", pop_word, v[15:0]);
        end

        // R3 overflow drops deepest, R2 top follows each push
        do_reset();
        for (int i = 1; i <= 9; i++) begin
            drive(C_PUSH, 16'h0000, 16'h1000 + 16'(i));
            chk("R2", "top after push", top_word, 16'h1000 + 16'(i));
        end
        for (int i = 9; i >= 2; i--) begin
            drive(C_POP, 16'h0000, 16'h0000);
            chk("R3", "popped word", pop_word, 16'h1000 + 16'(i));
        end
        // R4 underflow repeats the deepest slot
        chk("R4", "top after drain", top_word, 16'h1002);
        drive(C_POP, 16'h0000, 16'h0000);
        chk("R4", "extra pop", pop_word, 16'h1002);
        chk("R4", "top stays", top_word, 16'h1002);
        // R11 hold without advance
        drive(7'b0, 16'h0000, 16'h0000);
        chk("R11", "pc holds", pc, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule